// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block is a single check-node processor for a layered LDPC decoder. It takes up to eight variable-to-check messages in one cycle, one per column of the base matrix, and returns one check-to-variable message per edge. Each outgoing message carries the parity of the signs of all *other* participating edges. Its magnitude is the smallest magnitude among those other edges, lowered by a fixed offset and clamped so it never goes below zero.

The magnitude path makes one pass over the inputs. That pass finds the smallest magnitude, the second smallest, and the edge where the smallest sits. The edge at that index is given the second smallest value, and every other edge is given the smallest. Sign handling is a single XOR reduction over the participating edges, which each edge then XORs with its own sign again. The datapath uses only compares, subtractions and selects. Unused base-matrix positions are excluded through a per-edge mask. A decoder instantiates one copy per lifting index. Message storage and routing sit outside this block.

Messages are 6-bit sign-magnitude values. Edge `e` occupies bits `[6e+5:6e]` of the packed bus. The upper bit of each field is the sign (1 = negative), and the lower five bits are the magnitude.

Top module: `cn_minsum_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `out_msg` is loaded at the clock edge where `in_valid` is high.
- R2: For a participating edge `e`, the output magnitude is M − OFFSET when M > OFFSET and 0 otherwise. M is the minimum magnitude over the other participating edges, and OFFSET defaults to 1 LSB.
- R3: When the smallest magnitude occurs on two or more participating edges, every participating edge, including the ones holding the minimum, receives that smallest value minus the offset (floored at 0).
- R4: The output sign of a participating edge is the XOR of the sign bits (bit 5 of each field, 1 = negative) of all other participating edges.
- R5: An output field whose magnitude is 0 carries sign 0.
- R6: A masked edge (`in_mask[e]` = 0) produces an all-zero output field. Its input sign and magnitude have no effect on any other edge.
- R7: While `in_valid` is low, `out_msg` holds its last value regardless of `in_msg` and `in_mask`.
- R8: A participating edge with no other participating edge sees the magnitude 31 (all ones) and sign 0. Its output is therefore 31 − OFFSET with sign 0.
- R9: After a synchronous active-low reset, `out_valid` is 0 and `out_msg` is all zeros.
- R10: Field layout is fixed: edge `e` uses bits `[6e+5:6e]`, bit `6e+5` is the sign and bits `[6e+4:6e]` are the magnitude, on both input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input messages present this cycle |
| in_mask | input | 8 | Per-edge participation mask |
| in_msg | input | 48 | Packed variable-to-check messages, 6 bits per edge |
| out_valid | output | 1 | Output messages updated this cycle |
| out_msg | output | 48 | Packed check-to-variable messages, 6 bits per edge |

## Verification
Two functions can apply to the same edge in the same cycle. One swaps in the second-smallest magnitude for the edge that owns the minimum. The other forces a positive sign once the offset clamps a magnitude to zero. The bench provokes both together by placing magnitudes equal to the offset, or just above it, next to negative signs, including ties and the owning edge. A bit-level reference computes, for each edge, the minimum over the other edges independently, and each result is compared against it. Exhaustive sweeps over all 256 sign patterns and all 256 masks add cases where masking changes which edge owns the minimum at the same moment the parity changes.

// File: rtl/cn_minsum_pkg.sv
// Package: shared defaults and helpers for the offset min-sum check node unit.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time constant functions.
package cn_minsum_pkg;

    localparam int unsigned CN_DEG_DEF    = 8;  // edges per check row
    localparam int unsigned CN_MAG_W_DEF  = 5;  // magnitude bits per message
    localparam int unsigned CN_OFFSET_DEF = 1;  // offset in magnitude LSBs

    // Width of an index able to address n edges (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cn_min_search.sv
// Module: cn_min_search
// Finds the smallest and second-smallest magnitudes among the masked-in
// edges, plus the index of the smallest, in a single linear pass.
// Assumes: masked-out edges are treated as the all-ones magnitude; ties keep
// the lowest index as the minimum owner and place the repeat in min2.
module cn_min_search
    import cn_minsum_pkg::*;
#(
    parameter int unsigned DEG   = CN_DEG_DEF,
    parameter int unsigned MAG_W = CN_MAG_W_DEF,
    localparam int unsigned IDX_W = idx_width(DEG)
) (
    input  logic [DEG*MAG_W-1:0] mags,
    input  logic [DEG-1:0]       mask,
    output logic [MAG_W-1:0]     min1,
    output logic [MAG_W-1:0]     min2,
    output logic [IDX_W-1:0]     min1_idx
);

    // One-pass two-minimum search over participating edges.
    always_comb begin
        logic [MAG_W-1:0] cur;
        min1     = '1;
        min2     = '1;
        min1_idx = '0;
        cur      = '0;
        for (int e = 0; e < DEG; e++) begin
            cur = mags[e*MAG_W +: MAG_W];
            if (mask[e]) begin
                if (cur < min1) begin
                    min2     = min1;
                    min1     = cur;
                    min1_idx = IDX_W'(e);
                end else if (cur < min2) begin
                    min2 = cur;
                end
            end
        end
    end

endmodule

// File: rtl/cn_sign_parity.sv
// Module: cn_sign_parity
// XOR reduction of the sign bits of the participating edges.
// Assumes: a masked-out edge contributes a positive sign.
module cn_sign_parity
    import cn_minsum_pkg::*;
#(
    parameter int unsigned DEG = CN_DEG_DEF
) (
    input  logic [DEG-1:0] signs,
    input  logic [DEG-1:0] mask,
    output logic           parity
);

    // Parity of all participating signs.
    always_comb parity = ^(signs & mask);

endmodule

// File: rtl/cn_edge_out.sv
// Module: cn_edge_out
// Builds one outgoing message: picks min2 when this edge owns min1, else min1,
// subtracts the offset with a floor at zero, and removes the edge's own sign
// from the row parity. Zero magnitudes are emitted with a positive sign.
// Assumes: OFFSET fits in MAG_W bits.
module cn_edge_out
    import cn_minsum_pkg::*;
#(
    parameter int unsigned MAG_W  = CN_MAG_W_DEF,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned EDGE   = 0,
    parameter int unsigned OFFSET = CN_OFFSET_DEF
) (
    input  logic             active,
    input  logic             own_sign,
    input  logic             parity,
    input  logic [MAG_W-1:0] min1,
    input  logic [MAG_W-1:0] min2,
    input  logic [IDX_W-1:0] min1_idx,
    output logic [MAG_W:0]   msg
);

    localparam logic [MAG_W-1:0] OFS = MAG_W'(OFFSET);

    logic [MAG_W-1:0] pick;
    logic [MAG_W-1:0] mag;
    logic             sgn;

    // Exclude own contribution, apply saturating offset, canonicalise zero.
    always_comb begin
        pick = (min1_idx == IDX_W'(EDGE)) ? min2 : min1;
        mag  = (pick > OFS) ? (pick - OFS) : '0;
        sgn  = (mag == '0) ? 1'b0 : (parity ^ own_sign);
        msg  = active ? {sgn, mag} : '0;
    end

endmodule

// File: rtl/cn_minsum_unit.sv
// Module: cn_minsum_unit (top)
// Offset min-sum check node: DEG sign-magnitude messages in, DEG updated
// messages out, registered one cycle after in_valid. Edge e occupies
// bits [e*(MAG_W+1) +: MAG_W+1], sign in the top bit of each field.
// Assumes: synchronous active-low reset; outputs hold while in_valid is low.
module cn_minsum_unit
    import cn_minsum_pkg::*;
#(
    parameter int unsigned DEG    = CN_DEG_DEF,
    parameter int unsigned MAG_W  = CN_MAG_W_DEF,
    parameter int unsigned OFFSET = CN_OFFSET_DEF,
    localparam int unsigned MSG_W = MAG_W + 1,
    localparam int unsigned BUS_W = DEG * MSG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DEG-1:0]   in_mask,
    input  logic [BUS_W-1:0] in_msg,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_msg
);

    localparam int unsigned IDX_W = idx_width(DEG);

    logic [DEG*MAG_W-1:0] mags;
    logic [DEG-1:0]       signs;
    logic [MAG_W-1:0]     min1;
    logic [MAG_W-1:0]     min2;
    logic [IDX_W-1:0]     min1_idx;
    logic                 parity;
    logic [BUS_W-1:0]     next_msg;

    // Split the packed bus into sign and magnitude lanes.
    for (genvar e = 0; e < DEG; e++) begin : g_split
        assign mags[e*MAG_W +: MAG_W] = in_msg[e*MSG_W +: MAG_W];
        assign signs[e]               = in_msg[e*MSG_W + MAG_W];
    end

    cn_min_search #(.DEG(DEG), .MAG_W(MAG_W)) i_search (
        .mags    (mags),
        .mask    (in_mask),
        .min1    (min1),
        .min2    (min2),
        .min1_idx(min1_idx)
    );

    cn_sign_parity #(.DEG(DEG)) i_parity (
        .signs (signs),
        .mask  (in_mask),
        .parity(parity)
    );

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        cn_edge_out #(
            .MAG_W (MAG_W),
            .IDX_W (IDX_W),
            .EDGE  (e),
            .OFFSET(OFFSET)
        ) i_edge (
            .active  (in_mask[e]),
            .own_sign(signs[e]),
            .parity  (parity),
            .min1    (min1),
            .min2    (min2),
            .min1_idx(min1_idx),
            .msg     (next_msg[e*MSG_W +: MSG_W])
        );
    end

    // Output register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_msg <= next_msg;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid) else $error("valid latency"); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid) else $error("spurious valid"); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_msg)) else $error("output moved while idle"); // R7
    AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> (min1 <= min2)) else $error("min order"); // R2

    for (genvar e = 0; e < DEG; e++) begin : g_chk
        AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_mask[e]) |=> (out_msg[e*MSG_W +: MSG_W] == '0)) else $error("masked edge not zero"); // R6
        AST_MAG_LE_MIN2: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_mask[e]) |=> (out_msg[e*MSG_W +: MAG_W] <= $past(min2))) else $error("magnitude above min2"); // R2
        AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && (out_msg[e*MSG_W +: MAG_W] == '0)) |-> !out_msg[e*MSG_W + MAG_W]) else $error("negative zero"); // R5
    end

endmodule

// File: tb/test_cn_minsum_unit.sv
`timescale 1ns/1ps
module test_cn_minsum_unit;

    localparam int DEG = 8;
    localparam int OFF = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_mask = '0;
    logic [47:0] in_msg = '0;
    logic        out_valid;
    logic [47:0] out_msg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [47:0] last_exp = '0;

    always #5 clk = ~clk;

    cn_minsum_unit i_cn_minsum_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
        .in_msg(in_msg), .out_valid(out_valid), .out_msg(out_msg)
    );

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Reference: per edge, minimum and sign parity over the other edges (R2 R4 R5 R6 R8).
    function automatic logic [47:0] ref_out(input logic [7:0] m, input logic [47:0] x);
        logic [47:0] r = '0;
        for (int e = 0; e < DEG; e++) begin
            int mn = 31;
            int mg;
            logic par = 1'b0;
            if (m[e]) begin
                for (int j = 0; j < DEG; j++) begin
                    if (j != e && m[j]) begin
                        if (int'(x[j*6 +: 5]) < mn) mn = int'(x[j*6 +: 5]);
                        par = par ^ x[j*6 + 5];
                    end
                end
                mg = (mn > OFF) ? mn - OFF : 0;
                r[e*6 +: 5] = 5'(mg);
                r[e*6 + 5]  = (mg == 0) ? 1'b0 : par;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one vector, check the registered result and then the idle hold.
    task automatic apply(input string tag, input logic [7:0] m, input logic [47:0] x);
        logic [47:0] exp = ref_out(m, x);
        @(negedge clk);
        in_valid = 1'b1; in_mask = m; in_msg = x;
        @(negedge clk);
        in_valid = 1'b0; in_mask = ~m; in_msg = ~x;
        check("R1 valid", {47'd0, out_valid}, 48'd1);
        check(tag, out_msg, exp);
        @(negedge clk);
        check("R1 drop", {47'd0, out_valid}, 48'd0);
        check("R7 hold", out_msg, exp);
        last_exp = exp;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] x;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {47'd0, out_valid}, 48'd0);
        check("R9 reset msg", out_msg, 48'd0);
        rst_n = 1'b1;

        // R2: unique minimum at each position, several values incl. floor.
        foreach (x[i]) x[i] = 1'b0;
        for (int p = 0; p < DEG; p++) begin
            for (int v = 0; v < 6; v++) begin
                x = '0;
                for (int e = 0; e < DEG; e++) x[e*6 +: 6] = {1'b0, 5'd20 + 5'(e)};
                x[p*6 +: 5] = 5'(v * 6);
                apply("R2 unique min", 8'hFF, x);
            end
        end
        // R3: ties of the minimum on two edges.
        for (int p = 0; p < DEG; p++) begin
            x = '0;
            for (int e = 0; e < DEG; e++) x[e*6 +: 6] = {1'b1, 5'd17};
            x[p*6 +: 5] = 5'd3;
            x[((p + 3) % DEG)*6 +: 5] = 5'd3;
            apply("R3 tie", 8'hFF, x);
        end
        // R4: exhaustive sign patterns over distinct magnitudes.
        for (int s = 0; s < 256; s++) begin
            x = '0;
            for (int e = 0; e < DEG; e++) x[e*6 +: 6] = {s[e], 5'(e + 4)};
            apply("R4 signs", 8'hFF, x);
        end
        // R5: magnitudes at and just above the offset with negative signs.
        for (int k = 0; k < 64; k++) begin
            x = '0;
            for (int e = 0; e < DEG; e++) x[e*6 +: 6] = {1'b1, 5'(rnd() % 3)};
            apply("R5 zero sign", 8'(rnd()) | 8'h03, x);
        end
        // R8: single participating edge.
        for (int p = 0; p < DEG; p++) begin
            apply("R8 lone edge", 8'(1 << p), {rnd()[15:0], rnd()});
        end
        // R6 R10: exhaustive masks, masked edges given dominant small values.
        for (int m = 0; m < 256; m++) begin
            for (int r = 0; r < 3; r++) begin
                x = {rnd()[15:0], rnd()};
                for (int e = 0; e < DEG; e++) if (!m[e]) x[e*6 +: 6] = {1'b1, 5'd0};
                apply("R6 mask", 8'(m), x);
            end
        end
        // R10 general random patterns.
        for (int k = 0; k < 1000; k++) begin
            apply("R10 random", 8'(rnd()), {rnd()[15:0], rnd()});
        end
        // R7: idle cycles with changing inputs do not disturb the output.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_mask = 8'(rnd()); in_msg = {rnd()[15:0], rnd()};
            @(negedge clk);
            check("R7 idle", out_msg, last_exp);
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule